// File: doc/BRIEF.md
# Stereo DC-Removal Filter with Offset Hold

This block sits behind a decimation stage and removes any DC level from a stereo stream of 24-bit two's complement samples. Each channel keeps a running estimate of its DC offset in a leaky integrator and subtracts that estimate from every incoming sample. The integrator's time constant is 2^SHIFT sample periods. With the default SHIFT of 13 at a 48 kHz rate, the -3 dB corner lands near 1 Hz. The corner scales with the sample rate, and the loss at 20 Hz is only a fraction of a dB.

A hold input stops the estimate from moving. The value already learned keeps being subtracted, so the stage works as a one-shot offset calibration. The host runs the stream with hold low until the estimate has settled, which takes on the order of 10^5 samples at the default setting. It then raises hold, and the learned offset of everything upstream is cancelled from then on.

The accumulators advance only on the sample strobe. Each output is registered and holds its value between strobes.

Top module: `dc_trim_hpf`

## Requirements
- R1: A synchronous active-low reset clears both offset accumulators and both outputs to zero, so the first sample after reset appears at the output unchanged.
- R2: One clock after a clock edge with `smp_stb` high, each output equals that edge's input minus the channel's offset. The offset is the accumulator as it stood before that edge, arithmetically shifted right by SHIFT (floor).
- R3: The difference is saturated to the signed 24-bit range, to 0x7FFFFF or 0x800000, and never wraps. A non-negative input minus a negative offset never yields a negative output, and the reverse case never yields a non-negative one.
- R4: On a strobe with `hold_cal` low, the accumulator becomes acc + x - (acc >>> SHIFT), kept in W+SHIFT+1 bits.
- R5: On a strobe with `hold_cal` high, the accumulator keeps its value and the held offset is still subtracted from the sample.
- R6: Without a strobe, the accumulators and outputs keep their values whatever the sample inputs carry.
- R7: The left and right paths are independent. Each output depends only on its own channel's input history.
- R8: A constant input held with `hold_cal` low drives the channel's output to exactly zero once the estimate has settled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_stb | input | 1 | One-cycle strobe marking a valid sample pair |
| hold_cal | input | 1 | High: freeze both offset estimates, keep subtracting them |
| in_l | input | W | Left sample, signed |
| in_r | input | W | Right sample, signed |
| out_l | output | W | Left sample with offset removed, signed, saturated |
| out_r | output | W | Right sample with offset removed, signed, saturated |

## Verification
Subtraction and estimate update share a strobe edge. The case that matters is a hold change, or a saturating sample, that arrives on the same edge as the accumulator step. The bench toggles `hold_cal` exactly on strobe edges in the middle of a settled stream. It then trains each channel to one rail and feeds the opposite rail, so the clamp and the frozen offset act on the same sample. Every output is compared with an independent integer model that applies the pre-edge offset to the sample and only then decides whether the accumulator moves.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int DCR_NCH = 2;
  typedef enum logic [0:0] {
    DCR_LEFT  = 1'b0,
    DCR_RIGHT = 1'b1
  } dcr_chan_e;
endpackage

// File: rtl/dcr_offset_acc.sv
module dcr_offset_acc #(
  parameter int W = 24,
  parameter int S = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic                freeze,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] off
);
  localparam int AW = W + S + 1;

  logic signed [AW-1:0] acc;
  logic                 track_en;

  // acc holds the offset scaled by 2^S; one leak step toward the sample
  function automatic logic signed [AW-1:0] leak_step(
    input logic signed [AW-1:0] a,
    input logic signed [W-1:0]  s
  );
    logic signed [AW-1:0] xs;
    logic signed [AW-1:0] fb;
    xs = AW'(s);
    fb = a >>> S;
    return a + xs - fb;
  endfunction

  assign track_en = strobe & ~freeze;

  always_ff @(posedge clk) begin
    if (!rst_n)        acc <= '0;
    else if (track_en) acc <= leak_step(acc, x);
  end

  assign off = W'(acc >>> S);

  assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && freeze) |=> $stable(acc));
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(acc));
  assert_track_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !freeze && (x != off)) |=> !$stable(acc));
endmodule

// File: rtl/dcr_sub_sat.sv
module dcr_sub_sat #(
  parameter int W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] off,
  output logic signed [W-1:0] y
);
  localparam logic signed [W-1:0] POS_RAIL = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] NEG_RAIL = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] clamp_diff(
    input logic signed [W-1:0] a,
    input logic signed [W-1:0] b
  );
    logic signed [W:0] d;
    d = (W+1)'(a) - (W+1)'(b);
    if (d[W] != d[W-1]) return d[W] ? NEG_RAIL : POS_RAIL;
    return d[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      y <= '0;
    else if (strobe) y <= clamp_diff(x, off);
  end

  assert_no_wrap_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !x[W-1] && off[W-1]) |=> !y[W-1]);
  assert_no_wrap_neg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && x[W-1] && !off[W-1]) |=> y[W-1]);
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(y));
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (y == '0));
endmodule

// File: rtl/dcr_channel.sv
module dcr_channel #(
  parameter int W = 24,
  parameter int S = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe,
  input  logic                freeze,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] y
);
  logic signed [W-1:0] off_est;

  dcr_offset_acc #(.W(W), .S(S)) u_acc (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .freeze(freeze),
    .x(x), .off(off_est)
  );

  dcr_sub_sat #(.W(W)) u_sub (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .x(x), .off(off_est), .y(y)
  );
endmodule

// File: rtl/dc_trim_hpf.sv
module dc_trim_hpf
  import dcr_pkg::*;
#(
  parameter int W     = 24,
  parameter int SHIFT = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_stb,
  input  logic                hold_cal,
  input  logic signed [W-1:0] in_l,
  input  logic signed [W-1:0] in_r,
  output logic signed [W-1:0] out_l,
  output logic signed [W-1:0] out_r
);
  logic signed [W-1:0] ch_in  [DCR_NCH];
  logic signed [W-1:0] ch_out [DCR_NCH];

  assign ch_in[DCR_LEFT]  = in_l;
  assign ch_in[DCR_RIGHT] = in_r;

  for (genvar c = 0; c < DCR_NCH; c++) begin : g_ch
    dcr_channel #(.W(W), .S(SHIFT)) u_ch (
      .clk(clk), .rst_n(rst_n), .strobe(smp_stb), .freeze(hold_cal),
      .x(ch_in[c]), .y(ch_out[c])
    );
  end

  assign out_l = ch_out[DCR_LEFT];
  assign out_r = ch_out[DCR_RIGHT];
endmodule

// File: tb/sim_dc_trim_hpf.sv
`timescale 1ns/1ps
module sim_dc_trim_hpf;
  localparam int W = 24;
  localparam int S = 6;
  localparam longint PMAX = (longint'(1) <<< (W-1)) - 1;
  localparam longint NMIN = -(longint'(1) <<< (W-1));

  logic clk = 0;
  logic rst_n = 0;
  logic smp_stb = 0;
  logic hold_cal = 0;
  logic signed [W-1:0] in_l = '0, in_r = '0;
  logic signed [W-1:0] out_l, out_r;

  int n_run = 0, n_fail = 0;
  longint acc_l = 0, acc_r = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dc_trim_hpf #(.W(W), .SHIFT(S)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .hold_cal(hold_cal),
    .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r)
  );

  function automatic longint clampv(longint v);
    if (v > PMAX) return PMAX;
    if (v < NMIN) return NMIN;
    return v;
  endfunction

  function automatic longint floor_div(longint a);
    longint q;
    q = a / (longint'(1) <<< S);
    if (a < 0 && q * (longint'(1) <<< S) != a) q = q - 1;
    return q;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(longint xl, longint xr, bit frz, string tag);
    longint el, er, ol, orr;
    @(negedge clk);
    in_l = W'(xl); in_r = W'(xr); hold_cal = frz; smp_stb = 1;
    @(negedge clk);
    smp_stb = 0;
    ol = floor_div(acc_l); orr = floor_div(acc_r);
    el = clampv(xl - ol); er = clampv(xr - orr);
    check({tag, " left"},  longint'(out_l), el);
    check({tag, " right"}, longint'(out_r), er);
    if (!frz) begin
      acc_l = acc_l + xl - ol;
      acc_r = acc_r + xr - orr;
    end
  endtask

  task automatic idle_check(int n);
    longint hl, hr;
    hl = longint'(out_l); hr = longint'(out_r);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_l = W'($urandom); in_r = W'($urandom);
      hold_cal = 1'($urandom);
    end
    @(negedge clk);
    check("R6 idle hold left",  longint'(out_l), hl);
    check("R6 idle hold right", longint'(out_r), hr);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; smp_stb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    acc_l = 0; acc_r = 0;
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_fail++; n_run++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state and first sample passes unchanged
    check("R1 reset left",  longint'(out_l), 0);
    check("R1 reset right", longint'(out_r), 0);
    step(1000, -777, 0, "R1 first sample");

    // R2 R4 R7: random sweep, channels differ, idle gaps
    for (int i = 0; i < 300; i++) begin
      longint a, b;
      a = longint'($signed(W'($urandom)));
      b = (i % 2 == 0) ? longint'(-40000) : longint'($signed(W'($urandom)));
      step(a, b, 0, "R2 R4 R7 sweep");
      if (i % 37 == 0) idle_check(1 + (i % 5));
    end

    // R8: constant input settles to exactly zero
    for (int i = 0; i < 1500; i++) step(1193046, -5000, 0, "R8 settle");
    check("R8 settled left",  longint'(out_l), 0);
    check("R8 settled right", longint'(out_r), 0);

    // R5: freeze raised on a strobe edge, held offset still subtracted
    step(2097152, 100, 1, "R5 freeze edge");
    check("R5 frozen left value", longint'(out_l), 2097152 - 1193046);
    for (int i = 0; i < 20; i++)
      step(longint'($signed(W'($urandom))), -5000 + i, 1, "R5 frozen");
    step(-5000, 1193046, 0, "R5 release");
    idle_check(4);
    step(0, 0, 1, "R5 refrozen");

    // R3: train to opposite rails, then freeze and feed the other rail
    for (int i = 0; i < 1500; i++) step(NMIN, PMAX, 0, "R3 train");
    step(PMAX, NMIN, 1, "R3 clamp");
    check("R3 clamp high left", longint'(out_l), PMAX);
    check("R3 clamp low right", longint'(out_r), NMIN);
    step(PMAX - 5, NMIN + 3, 1, "R3 clamp again");
    step(0, 0, 1, "R3 zero frozen");

    // R1: reset mid-stream clears the estimate
    do_reset();
    check("R1 mid reset left",  longint'(out_l), 0);
    step(-12345, 54321, 0, "R1 after reset");
    check("R1 raw after reset right", longint'(out_r), 54321);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule